// File: doc/BRIEF.md
# Stack Pointer Push/Pop Unit

This unit holds a dedicated 16-bit stack pointer and produces the memory address and byte lanes for each stack access. A push moves the pointer down by the operand size and then stores at the new pointer value. A pop loads from the current pointer value and then moves the pointer up by the operand size. The operand is either a general register, stacked as a 16-bit word, or the visible 8-bit half of the status register, stacked as one byte. The memory itself sits outside the unit. The unit only presents the access on a valid/ready handshake.

The pointer can also be written directly from register 0. Its current value is always shown on a read port, so that register 0 can copy it. A direct load takes priority. A push or pop issued in the same cycle is turned away and flagged, and the pointer takes the loaded value.

Back-pressure rules: `acc_valid` is raised whenever a push or pop command is present and no direct load is active. The pointer moves only in a cycle where `acc_valid` and `acc_ready` are both high. While `acc_ready` is low, the pointer holds its value. The command must be held by the issuer, and the address and byte lanes stay unchanged.

Top module: `sp_unit`

## Requirements
- R1: After reset (`rst_n` low, active low), `sp_value` equals the parameter `SP_RESET` (default 0x0000).
- R2: A push (`op` = 2'b01) presents `acc_addr` = pointer − step. After the handshake completes, the pointer equals that address.
- R3: A pop (`op` = 2'b10) presents `acc_addr` = the current pointer. After the handshake completes, the pointer equals the old pointer + step.
- R4: The step is 2 when `opnd_byte` = 0 (word operand) and 1 when `opnd_byte` = 1 (status byte operand).
- R5: A word access drives `acc_be` = 2'b11. A byte access drives `acc_be` = 2'b01, which enables only the low byte.
- R6: Pointer arithmetic and addresses wrap modulo 2^16. A word push at 0x0000 addresses 0xFFFE, and a byte pop at 0xFFFF leaves 0x0000.
- R7: With `ld_en` high, the pointer takes `ld_val` at the next clock edge. `sp_value` always shows the current pointer.
- R8: A push or pop in the same cycle as `ld_en` is rejected. `acc_valid` is 0, `op_reject` is 1, and the loaded value wins.
- R9: While `acc_valid` is 1 and `acc_ready` is 0, the pointer does not change.
- R10: `op` = 2'b00 (idle) or 2'b11 (reserved) makes no access: `acc_valid` is 0, `op_reject` is 0, and the pointer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 2 | 00 idle, 01 push, 10 pop, 11 reserved (idle) |
| opnd_byte | input | 1 | 1: 8-bit status operand, 0: 16-bit register operand |
| ld_en | input | 1 | Direct pointer load from register 0 |
| ld_val | input | 16 | Value loaded into the pointer |
| acc_ready | input | 1 | Memory accepts the presented access |
| acc_valid | output | 1 | A stack access is presented |
| acc_addr | output | 16 | Byte address of the access |
| acc_be | output | 2 | Byte lane enables, bit 0 = low byte |
| op_reject | output | 1 | Push/pop turned away because of a direct load |
| sp_value | output | 16 | Current pointer, readable into register 0 |

## Verification
Push and pop are each exercised with both operand widths from a mid-range pointer. A full push/pop round trip must return the pointer to its start, which separates a correct pre-decrement/post-increment pair from a swapped one. Word and byte steps near 0x0000 and 0xFFFF show whether the wrap is modulo 2^16. A push held against a low `acc_ready`, a push or pop colliding with a direct load, and the reserved op code check that the pointer moves only on a completed handshake. A reset applied mid-run confirms the reset value.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    SP_IDLE = 2'b00,
    SP_PUSH = 2'b01,
    SP_POP  = 2'b10,
    SP_RSVD = 2'b11
  } sp_op_e;

  localparam int unsigned LANES = 2;
endpackage

// File: rtl/sp_addr_gen.sv
module sp_addr_gen
  import sp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]     sp_cur,
  input  logic [1:0]       op,
  input  logic             opnd_byte,
  output logic             is_access,
  output logic [W-1:0]     addr,
  output logic [W-1:0]     sp_nxt,
  output logic [LANES-1:0] be
);
  localparam logic [W-1:0] STEP_WORD = W'(LANES);
  localparam logic [W-1:0] STEP_BYTE = W'(1);

  logic [W-1:0] step;
  logic [W-1:0] dec_val;
  logic [W-1:0] inc_val;

  assign step    = opnd_byte ? STEP_BYTE : STEP_WORD;
  assign dec_val = sp_cur - step;
  assign inc_val = sp_cur + step;
  assign be      = opnd_byte ? LANES'(1) : {LANES{1'b1}};

  always_comb begin
    is_access = 1'b0;
    addr      = sp_cur;
    sp_nxt    = sp_cur;
    unique case (sp_op_e'(op))
      SP_PUSH: begin
        is_access = 1'b1;
        addr      = dec_val;
        sp_nxt    = dec_val;
      end
      SP_POP: begin
        is_access = 1'b1;
        addr      = sp_cur;
        sp_nxt    = inc_val;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sp_reg.sv
module sp_reg #(
  parameter int unsigned     W     = 16,
  parameter logic [W-1:0]    RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         upd_en,
  input  logic [W-1:0] upd_val,
  output logic [W-1:0] sp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sp_q <= RST_V;
    else if (ld_en)  sp_q <= ld_val;
    else if (upd_en) sp_q <= upd_val;
  end

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> sp_q == $past(ld_val));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !upd_en) |=> $stable(sp_q));
endmodule

// File: rtl/sp_unit.sv
module sp_unit
  import sp_pkg::*;
#(
  parameter int unsigned  SP_W     = 16,
  parameter logic [15:0]  SP_RESET = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op,
  input  logic             opnd_byte,
  input  logic             ld_en,
  input  logic [SP_W-1:0]  ld_val,
  input  logic             acc_ready,
  output logic             acc_valid,
  output logic [SP_W-1:0]  acc_addr,
  output logic [LANES-1:0] acc_be,
  output logic             op_reject,
  output logic [SP_W-1:0]  sp_value
);
  localparam logic [SP_W-1:0] RST_V = SP_W'(SP_RESET);

  logic            is_access;
  logic [SP_W-1:0] sp_nxt;
  logic            upd_en;

  sp_addr_gen #(.W(SP_W)) u_gen (
    .sp_cur    (sp_value),
    .op        (op),
    .opnd_byte (opnd_byte),
    .is_access (is_access),
    .addr      (acc_addr),
    .sp_nxt    (sp_nxt),
    .be        (acc_be)
  );

  assign acc_valid = is_access && !ld_en;
  assign op_reject = is_access && ld_en;
  assign upd_en    = acc_valid && acc_ready;

  sp_reg #(.W(SP_W), .RST_V(RST_V)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_val  (ld_val),
    .upd_en  (upd_en),
    .upd_val (sp_nxt),
    .sp_q    (sp_value)
  );

  // R2
  push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && op == 2'b01) |=> sp_value == $past(acc_addr));

  // R3
  pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && op == 2'b10) |-> acc_addr == sp_value);

  // R5
  word_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !opnd_byte) |-> acc_be == 2'b11);

  // R8
  reject_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && op_reject));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready) |=> sp_value == $past(sp_value));
endmodule

// File: tb/test_sp_unit.sv
module test_sp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        opnd_byte = 1'b0;
  logic        ld_en = 1'b0;
  logic [15:0] ld_val = 16'h0;
  logic        acc_ready = 1'b1;
  logic        acc_valid;
  logic [15:0] acc_addr;
  logic [1:0]  acc_be;
  logic        op_reject;
  logic [15:0] sp_value;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_unit i_sp_unit (
    .clk(clk), .rst_n(rst_n), .op(op), .opnd_byte(opnd_byte),
    .ld_en(ld_en), .ld_val(ld_val), .acc_ready(acc_ready),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_be(acc_be),
    .op_reject(op_reject), .sp_value(sp_value)
  );

  // op, byte, ld, ld_val, ready | exp addr, exp be, exp valid, exp reject, exp sp after
  localparam logic [56:0] VEC [NV] = '{
    {2'b00,1'b0,1'b1,16'h1000,1'b1, 16'h0000,2'b00,1'b0,1'b0,16'h1000}, // R7 load
    {2'b01,1'b0,1'b0,16'h0000,1'b1, 16'h0FFE,2'b11,1'b1,1'b0,16'h0FFE}, // R2 R4 R5 word push
    {2'b01,1'b1,1'b0,16'h0000,1'b1, 16'h0FFD,2'b01,1'b1,1'b0,16'h0FFD}, // R2 R4 R5 byte push
    {2'b10,1'b1,1'b0,16'h0000,1'b1, 16'h0FFD,2'b01,1'b1,1'b0,16'h0FFE}, // R3 byte pop
    {2'b10,1'b0,1'b0,16'h0000,1'b1, 16'h0FFE,2'b11,1'b1,1'b0,16'h1000}, // R3 word pop
    {2'b01,1'b0,1'b0,16'h0000,1'b0, 16'h0FFE,2'b11,1'b1,1'b0,16'h1000}, // R9 stalled
    {2'b01,1'b0,1'b1,16'h2000,1'b1, 16'h0000,2'b00,1'b0,1'b1,16'h2000}, // R8 push vs load
    {2'b00,1'b0,1'b0,16'h0000,1'b1, 16'h0000,2'b00,1'b0,1'b0,16'h2000}, // R10 idle
    {2'b00,1'b0,1'b1,16'h0000,1'b1, 16'h0000,2'b00,1'b0,1'b0,16'h0000}, // R7 load zero
    {2'b01,1'b0,1'b0,16'h0000,1'b1, 16'hFFFE,2'b11,1'b1,1'b0,16'hFFFE}, // R6 wrap down
    {2'b10,1'b0,1'b0,16'h0000,1'b1, 16'hFFFE,2'b11,1'b1,1'b0,16'h0000}, // R6 wrap up
    {2'b00,1'b0,1'b1,16'hFFFF,1'b1, 16'h0000,2'b00,1'b0,1'b0,16'hFFFF}, // R7 load top
    {2'b10,1'b1,1'b0,16'h0000,1'b1, 16'hFFFF,2'b01,1'b1,1'b0,16'h0000}, // R6 byte pop wrap
    {2'b11,1'b0,1'b0,16'h0000,1'b1, 16'h0000,2'b00,1'b0,1'b0,16'h0000}, // R10 reserved
    {2'b10,1'b0,1'b1,16'h1234,1'b1, 16'h0000,2'b00,1'b0,1'b1,16'h1234}  // R8 pop vs load
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk("R1 reset sp", sp_value, 16'h0000);
    chk("R1 reset valid", {15'h0, acc_valid}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {op, opnd_byte, ld_en, ld_val, acc_ready} = VEC[i][56:36];
      #1;
      chk($sformatf("R2/R3/R8/R10 vec%0d valid", i), {15'h0, acc_valid}, {15'h0, VEC[i][17]});
      chk($sformatf("R8 vec%0d reject", i), {15'h0, op_reject}, {15'h0, VEC[i][16]});
      if (VEC[i][17]) begin
        chk($sformatf("R2/R3/R6 vec%0d addr", i), acc_addr, VEC[i][35:20]);
        chk($sformatf("R5 vec%0d be", i), {14'h0, acc_be}, {14'h0, VEC[i][19:18]});
      end
      @(posedge clk);
      #1;
      chk($sformatf("R4/R7/R9 vec%0d sp", i), sp_value, VEC[i][15:0]);
    end
    // R1: mid-run reset returns pointer to reset value
    @(negedge clk);
    op = 2'b00; ld_en = 1'b1; ld_val = 16'h5555;
    @(negedge clk);
    ld_en = 1'b0;
    chk("R7 pre-reset load", sp_value, 16'h5555);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset", sp_value, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: stall over several cycles, then release
    @(negedge clk);
    op = 2'b01; opnd_byte = 1'b1; acc_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 long stall sp", sp_value, 16'h0000);
    chk("R9 long stall addr", acc_addr, 16'hFFFF);
    acc_ready = 1'b1;
    @(negedge clk);
    op = 2'b00;
    chk("R2 R6 released byte push", sp_value, 16'hFFFF);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule